// File: doc/BRIEF.md
# Multicycle Load/Store Processor Controller

This block is the control unit and datapath of a small non-pipelined load/store processor. Each instruction moves through up to five states: fetch, decode with register read, execute or address calculation, memory access or branch completion, and write-back. A finite-state sequencer decodes the opcode and function fields held in the instruction register. For each state it drives the register enables, the memory strobes, the ALU operation and the multiplexer selects of the internal registers. Those registers hold the instruction, the next PC, the two operands, the extended immediate, the ALU result, the branch condition and the loaded data.

One memory port serves both instruction fetch and data access. The memory must return read data combinationally in the same cycle as the address. Stores and branches finish after the memory state. ALU operations and loads continue into write-back. A one-cycle `done` pulse marks the final state of every instruction, so the cycles each instruction takes can be counted at the ports.

Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0].

Top module: `mc_core`

## Requirements
- R1: After reset and after every `done`, the next cycle is a fetch. In a fetch, `mem_ifetch` and `mem_rd` are high and `mem_addr` equals the PC. An instruction that is neither a taken branch nor a jump moves the PC by 4.
- R2: Register-immediate ops sign-extend the 16-bit immediate and write the result to rt. The opcodes are 0x08 add, 0x0C and, 0x0D or and 0x0E xor.
- R3: Opcode 0x00 is a register-register op that writes rs op rt to rd. The function codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x26 xor and 0x2A signed set-less-than.
- R4: A load (opcode 0x23) reads memory at rs + sign-extended immediate and writes the word to the register named by bits [15:11], taking five cycles.
- R5: A store (opcode 0x2B) writes rt to memory at rs + sign-extended immediate with a single `mem_wr` cycle, taking four cycles.
- R6: Opcode 0x04 branches when rs is zero and opcode 0x05 branches when rs is non-zero. The target is (PC + 4) + sign-extended immediate. A branch takes four cycles, taken or not.
- R7: ALU ops and loads take exactly five cycles. `done` is high only in the last cycle of each instruction.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: An undefined opcode, or an undefined function under opcode 0x00, pulses `illegal` together with `done` in the second cycle. It writes no register and no memory, and the PC moves to the next word.
- R10: While `rst` is high (synchronous, active high), the block sits in fetch with PC = `RESET_PC`, `mem_wr`, `done` and `illegal` low, and all registers cleared. Reset in the middle of an instruction abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address: PC during fetch, ALU result otherwise |
| mem_rd | output | 1 | Memory read strobe (fetch or load) |
| mem_wr | output | 1 | Memory write strobe (store) |
| mem_ifetch | output | 1 | High when the read is an instruction fetch |
| mem_wdata | output | 32 | Store data (rt operand) |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| done | output | 1 | One-cycle pulse on the last state of each instruction |
| illegal | output | 1 | One-cycle pulse for an undefined instruction |

## Verification
The assertions assume that `mem_rdata` settles within the cycle in which the address is presented. The bench's memory model meets this by answering combinationally from `mem_addr`. The assertions also assume that reset is held for at least one clock edge before checking begins, so `disable iff` covers the cleared state. The program stays within word-aligned addresses and defined encodings, except for the two encodings that deliberately exercise the illegal path. A taken branch at the end of the program holds execution in a loop, so the sequencer never fetches from memory that was not loaded.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN     = 32;
    localparam int REG_AW   = 5;
    localparam int NREG     = 1 << REG_AW;
    localparam int IMM_W    = 16;
    localparam int WORD_INC = XLEN / 8;

    // instruction field positions
    localparam int OPC_LSB = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;

    // primary opcodes
    localparam logic [5:0] OPC_RR    = 6'h00;
    localparam logic [5:0] OPC_BEQZ  = 6'h04;
    localparam logic [5:0] OPC_BNEZ  = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_XORI  = 6'h0E;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    // function codes under OPC_RR
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
    } state_t;

    typedef enum logic [2:0] {
        CL_RR, CL_IMM, CL_LOAD, CL_STORE, CL_BRZ, CL_BRNZ, CL_BAD
    } iclass_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
    } alu_op_t;

    typedef struct packed {
        iclass_t cls;
        alu_op_t op;
    } decode_t;

    typedef struct packed {
        logic    ifetch;
        logic    mem_rd;
        logic    mem_wr;
        logic    ir_we;
        logic    npc_we;
        logic    opnd_we;
        logic    alu_we;
        logic    cond_we;
        logic    cond_nz;
        logic    lmd_we;
        logic    pc_we;
        logic    pc_take;
        logic    rf_we;
        logic    a_sel_npc;
        logic    b_sel_imm;
        logic    wb_sel_lmd;
        logic    dst_sel_rt;
        logic    done;
        logic    illegal;
        alu_op_t alu_op;
    } ctl_t;

    function automatic decode_t decode_instr(input logic [5:0] opc, input logic [5:0] fn);
        decode_t d;
        d.cls = CL_BAD;
        d.op  = ALU_ADD;
        case (opc)
            OPC_RR: begin
                d.cls = CL_RR;
                case (fn)
                    FN_ADD:  d.op = ALU_ADD;
                    FN_SUB:  d.op = ALU_SUB;
                    FN_AND:  d.op = ALU_AND;
                    FN_OR:   d.op = ALU_OR;
                    FN_XOR:  d.op = ALU_XOR;
                    FN_SLT:  d.op = ALU_SLT;
                    default: d.cls = CL_BAD;
                endcase
            end
            OPC_ADDI:  begin d.cls = CL_IMM; d.op = ALU_ADD; end
            OPC_ANDI:  begin d.cls = CL_IMM; d.op = ALU_AND; end
            OPC_ORI:   begin d.cls = CL_IMM; d.op = ALU_OR;  end
            OPC_XORI:  begin d.cls = CL_IMM; d.op = ALU_XOR; end
            OPC_LOAD:  d.cls = CL_LOAD;
            OPC_STORE: d.cls = CL_STORE;
            OPC_BEQZ:  d.cls = CL_BRZ;
            OPC_BNEZ:  d.cls = CL_BRNZ;
            default:   d.cls = CL_BAD;
        endcase
        return d;
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  alu_op_t       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    localparam int N = 1 << AW;

    logic [DW-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    AST_R0_HELD: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0); // R8

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       cond,
    output ctl_t       ctl
);
    state_t  state, nxt;
    decode_t dec;
    logic    is_br;

    assign dec   = decode_instr(opcode, funct);
    assign is_br = (dec.cls == CL_BRZ) || (dec.cls == CL_BRNZ);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        ctl = '0;
        nxt = state;
        case (state)
            ST_FETCH: begin
                ctl.ifetch = 1'b1;
                ctl.mem_rd = 1'b1;
                ctl.ir_we  = 1'b1;
                ctl.npc_we = 1'b1;
                nxt        = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.opnd_we = 1'b1;
                if (dec.cls == CL_BAD) begin
                    ctl.illegal = 1'b1;
                    ctl.done    = 1'b1;
                    ctl.pc_we   = 1'b1;
                    nxt         = ST_FETCH;
                end else begin
                    nxt = ST_EXEC;
                end
            end
            ST_EXEC: begin
                ctl.alu_we    = 1'b1;
                ctl.alu_op    = ((dec.cls == CL_RR) || (dec.cls == CL_IMM)) ? dec.op : ALU_ADD;
                ctl.a_sel_npc = is_br;
                ctl.b_sel_imm = (dec.cls != CL_RR);
                ctl.cond_we   = is_br;
                ctl.cond_nz   = (dec.cls == CL_BRNZ);
                nxt           = ST_MEM;
            end
            ST_MEM: begin
                ctl.pc_we   = 1'b1;
                ctl.pc_take = is_br && cond;
                if (dec.cls == CL_LOAD) begin
                    ctl.mem_rd = 1'b1;
                    ctl.lmd_we = 1'b1;
                end
                ctl.mem_wr = (dec.cls == CL_STORE);
                if ((dec.cls == CL_STORE) || is_br) begin
                    ctl.done = 1'b1;
                    nxt      = ST_FETCH;
                end else begin
                    nxt = ST_WB;
                end
            end
            ST_WB: begin
                ctl.rf_we      = 1'b1;
                ctl.wb_sel_lmd = (dec.cls == CL_LOAD);
                ctl.dst_sel_rt = (dec.cls == CL_IMM);
                ctl.done       = 1'b1;
                nxt            = ST_FETCH;
            end
            default: nxt = ST_FETCH;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ctl.done); // R7
    AST_FETCH_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> ctl.ifetch); // R1
    AST_ILLEGAL_ENDS: assert property (@(posedge clk) disable iff (rst)
        ctl.illegal |-> ctl.done); // R9
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        ctl.illegal |=> ctl.ifetch && !ctl.rf_we && !ctl.mem_wr); // R9

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            mem_ifetch,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            done,
    output logic            illegal
);
    ctl_t ctl;

    logic [XLEN-1:0] pc, ir, npc, a_q, b_q, imm_q, alu_q, lmd_q;
    logic            cond_q;

    logic [XLEN-1:0] rf_rd1, rf_rd2, alu_a, alu_b, alu_y, wb_data;
    logic [REG_AW-1:0] rs_f, rt_f, rd_f, wb_addr;

    assign rs_f = ir[RS_LSB +: REG_AW];
    assign rt_f = ir[RT_LSB +: REG_AW];
    assign rd_f = ir[RD_LSB +: REG_AW];

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir[OPC_LSB +: 6]),
        .funct  (ir[5:0]),
        .cond   (cond_q),
        .ctl    (ctl)
    );

    mc_regfile #(.AW(REG_AW), .DW(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (rs_f),
        .ra2 (rt_f),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we  (ctl.rf_we),
        .wa  (wb_addr),
        .wd  (wb_data)
    );

    assign alu_a = ctl.a_sel_npc ? npc : a_q;
    assign alu_b = ctl.b_sel_imm ? imm_q : b_q;

    mc_alu #(.DW(XLEN)) u_alu (
        .op (ctl.alu_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign wb_addr = ctl.dst_sel_rt ? rt_f : rd_f;
    assign wb_data = ctl.wb_sel_lmd ? lmd_q : alu_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= RESET_PC;
            ir     <= '0;
            npc    <= '0;
            a_q    <= '0;
            b_q    <= '0;
            imm_q  <= '0;
            alu_q  <= '0;
            cond_q <= 1'b0;
            lmd_q  <= '0;
        end else begin
            if (ctl.ir_we)   ir  <= mem_rdata;
            if (ctl.npc_we)  npc <= pc + XLEN'(WORD_INC);
            if (ctl.opnd_we) begin
                a_q   <= rf_rd1;
                b_q   <= rf_rd2;
                imm_q <= sext_imm(ir[IMM_W-1:0]);
            end
            if (ctl.alu_we)  alu_q  <= alu_y;
            if (ctl.cond_we) cond_q <= (a_q == '0) ^ ctl.cond_nz;
            if (ctl.lmd_we)  lmd_q  <= mem_rdata;
            if (ctl.pc_we)   pc     <= ctl.pc_take ? alu_q : npc;
        end
    end

    assign mem_addr   = ctl.ifetch ? pc : alu_q;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign mem_ifetch = ctl.ifetch;
    assign mem_wdata  = b_q;
    assign done       = ctl.done;
    assign illegal    = ctl.illegal;

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R5
    AST_LOAD_WRITES_BACK: assert property (@(posedge clk) disable iff (rst)
        ctl.lmd_we |=> ctl.rf_we && ctl.wb_sel_lmd); // R4

endmodule

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_ifetch, done, illegal;

    always #2 clk = ~clk;

    mc_core dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_ifetch(mem_ifetch), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal)
    );

    logic [31:0] mem [1024];
    assign mem_rdata = mem[mem_addr[11:2]];

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] ins;
        logic [3:0]  cyc;
        logic        ill;
        logic        st;
        logic [31:0] sa;
        logic [31:0] sd;
        logic [3:0]  tg;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{32'h00, 32'h20010005, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd2}, // addi r1=5
        '{32'h04, 32'h2002FFFD, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd2}, // addi r2=-3
        '{32'h08, 32'h00221820, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd3}, // add r3=r1+r2
        '{32'h0C, 32'hAC030100, 4'd4, 1'b0, 1'b1, 32'h100, 32'h2,        4'd3},
        '{32'h10, 32'h00412022, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd3}, // sub r4=r2-r1
        '{32'h14, 32'hAC040104, 4'd4, 1'b0, 1'b1, 32'h104, 32'hFFFFFFF8, 4'd3},
        '{32'h18, 32'h8C002904, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd4}, // load to r5
        '{32'h1C, 32'hAC050108, 4'd4, 1'b0, 1'b1, 32'h108, 32'h12345678, 4'd4},
        '{32'h20, 32'h10600008, 4'd4, 1'b0, 1'b0, 32'h0,   32'h0,        4'd6}, // beqz r3 not taken
        '{32'h24, 32'h14600008, 4'd4, 1'b0, 1'b0, 32'h0,   32'h0,        4'd6}, // bnez r3 -> 0x30
        '{32'h30, 32'hFC000000, 4'd2, 1'b1, 1'b0, 32'h0,   32'h0,        4'd9}, // bad opcode
        '{32'h34, 32'h20000007, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd8}, // addi r0=7
        '{32'h38, 32'hAC00010C, 4'd4, 1'b0, 1'b1, 32'h10C, 32'h0,        4'd8},
        '{32'h3C, 32'h00A43026, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd3}, // xor r6=r5^r4
        '{32'h40, 32'h0022083F, 4'd2, 1'b1, 1'b0, 32'h0,   32'h0,        4'd9}, // bad function
        '{32'h44, 32'hAC060110, 4'd4, 1'b0, 1'b1, 32'h110, 32'hEDCBA980, 4'd3},
        '{32'h48, 32'hAC010114, 4'd4, 1'b0, 1'b1, 32'h114, 32'h5,        4'd9},
        '{32'h4C, 32'h0041382A, 4'd5, 1'b0, 1'b0, 32'h0,   32'h0,        4'd3}, // slt r7=(r2<r1)
        '{32'h50, 32'hAC070118, 4'd4, 1'b0, 1'b1, 32'h118, 32'h1,        4'd3},
        '{32'h54, 32'hAC02011C, 4'd4, 1'b0, 1'b1, 32'h11C, 32'hFFFFFFFD, 4'd2},
        '{32'h58, 32'h1000FFFC, 4'd4, 1'b0, 1'b0, 32'h0,   32'h0,        4'd6}  // beqz r0 -> self
    };

    int nchk = 0;
    int nfail = 0;

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int i = 0; i < NV; i++) mem[VEC[i].pc[11:2]] = VEC[i].ins;
        mem[32'h28 >> 2] = 32'hAC01010C; // skipped by the taken branch
        mem[32'h2C >> 2] = 32'hAC01010C;
        mem[32'h904 >> 2] = 32'h12345678; // load source

        // R10 reset state
        repeat (3) @(negedge clk);
        check(mem_ifetch && mem_rd, "R10", "fetch during reset", {30'd0, mem_ifetch, mem_rd}, 32'h3);
        check(mem_addr == 32'h0, "R10", "reset PC", mem_addr, 32'h0);
        check(!mem_wr && !done && !illegal, "R10", "strobes low in reset",
              {29'd0, mem_wr, done, illegal}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            int    cyc;
            int    nwr;
            string ftag;
            cyc  = 0;
            nwr  = 0;
            ftag = (i > 0 && (VEC[i-1].ins[31:27] == 5'b00010)) ? "R6" : "R1";
            forever begin
                cyc++;
                if (cyc == 1) begin
                    check(mem_ifetch && mem_addr == VEC[i].pc, ftag, "fetch address",
                          mem_addr, VEC[i].pc);
                end
                if (mem_wr) begin
                    nwr++;
                    check(VEC[i].st && mem_addr == VEC[i].sa, "R5", "store address",
                          mem_addr, VEC[i].sa);
                    check(mem_wdata == VEC[i].sd, tname(VEC[i].tg), "store data",
                          mem_wdata, VEC[i].sd);
                    mem[mem_addr[11:2]] = mem_wdata;
                end
                if (done || cyc > 12) break;
                @(negedge clk);
            end
            check(cyc == int'(VEC[i].cyc),
                  VEC[i].ill ? "R9" : (VEC[i].cyc == 4'd5) ? "R7" :
                  (VEC[i].ins[31:27] == 5'b00010) ? "R6" : "R5",
                  "cycles per instruction", cyc, {28'd0, VEC[i].cyc});
            check(illegal == VEC[i].ill, VEC[i].ill ? "R9" : "R1", "illegal flag",
                  {31'd0, illegal}, {31'd0, VEC[i].ill});
            check(nwr == (VEC[i].st ? 1 : 0), VEC[i].ill ? "R9" : "R5", "write count",
                  nwr, VEC[i].st ? 1 : 0);
            @(negedge clk);
        end

        // R6 self-loop branch refetches its own address
        check(mem_ifetch && mem_addr == 32'h58, "R6", "branch back to itself", mem_addr, 32'h58);

        // R10 reset in the middle of an instruction
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(mem_ifetch && mem_addr == 32'h0 && !mem_wr, "R10", "mid-instruction reset",
              mem_addr, 32'h0);
        rst = 1'b0;
        begin
            int cyc;
            cyc = 0;
            forever begin
                cyc++;
                if (done || cyc > 12) break;
                @(negedge clk);
            end
            check(cyc == 5, "R7", "first instruction after reset", cyc, 5);
            @(negedge clk);
            check(mem_ifetch && mem_addr == 32'h4, "R1", "PC advance after reset", mem_addr, 32'h4);
        end

        finish_run();
    end

endmodule